// File: doc/BRIEF.md
# Selectable RF Line Data Encoder

This block sits between a serial bit source and an RF transmitter. It turns the stream into the level that keys the carrier. A 2-bit mode field picks the coding. Three modes take bits from a valid/ready stream: Manchester, bi-phase (mark), or plain NRZ. The fourth mode ignores the stream, and a single direct-drive bit steers the line. All timing comes from a half-bit-period strobe. Manchester and bi-phase spend two strobes on each bit. NRZ spends one strobe per bit, so software can build Manchester symbols itself and mix them with plain NRZ bits.

A modulation-select bit decides how the coded level reaches the radio. With on-off keying, the key line simply follows the level. With frequency keying, the key line holds the carrier on while the encoder is active, and the data-one line picks the synthesizer's divider ratio for a one or for a zero.

Configuration is written through a one-cycle strobe. A new coding mode never cuts a bit short, because it is adopted only at the next bit boundary. The module reset returns the block to Manchester with on-off keying.

Top module: `rf_line_encoder`

## Requirements
- R1: Mode value 2'b00 (Manchester): an accepted 1 gives data_one high for the first half-bit strobe interval and low for the second; an accepted 0 gives low, then high.
- R2: Mode value 2'b01 (bi-phase mark): the level toggles at the start of every bit and toggles again at mid-bit only for a 1. The running level is low whenever a burst starts from idle.
- R3: Mode value 2'b10 (NRZ): each accepted bit occupies exactly one strobe interval, and data_one equals the bit.
- R4: Mode value 2'b11 (direct): data_one takes the value of direct_bit one clock later, whether or not a strobe is present. in_ready stays low, so the stream is never consumed.
- R5: in_ready is high only in a cycle with half_tick high at a bit boundary. In Manchester and bi-phase a boundary is every second strobe; in NRZ it is every strobe. Each stream bit is consumed exactly once.
- R6: If in_valid is low at a boundary in a buffered mode, then after that strobe busy, data_one and key_out are all low.
- R7: With the modulation-select bit at 0 (on-off keying), key_out equals data_one.
- R8: With the modulation-select bit at 1 (frequency keying), key_out is high while busy is high or the direct mode is active, and data_one carries the coded level.
- R9: A mode written through cfg_we takes effect at the next bit boundary. The bit in progress completes in its old coding.
- R10: The synchronous reset clears the mode to Manchester, clears the modulation-select bit, and drives key_out, data_one and busy low.
- R11: Outputs are registered and change only on a clock edge at which half_tick is high. The exceptions are direct mode and a cfg_we write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high module reset |
| half_tick | input | 1 | One-cycle strobe once per half-bit period |
| in_valid | input | 1 | Stream bit present |
| in_data | input | 1 | Stream bit value |
| in_ready | output | 1 | Stream bit taken at this clock edge when in_valid is high |
| direct_bit | input | 1 | Line level used in direct mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Requested coding mode |
| cfg_fsk | input | 1 | Modulation select: 0 on-off keying, 1 frequency keying |
| key_out | output | 1 | Carrier keying line |
| data_one | output | 1 | Coded level / data-one divider select |
| busy | output | 1 | A buffered bit is being sent |

## Verification
The bench sweeps every 4-bit pattern through each buffered mode under both modulation settings. It predicts every half-bit level arithmetically. This exposes a Manchester polarity swap, a bi-phase encoder that misses the mid-bit toggle or starts from the wrong level, and an NRZ path that stretches bits to two strobes. Separate runs change the mode in the middle of a bit. A design that adopted the mode at once would emit a truncated symbol, and the sampled levels would differ. The bench also checks that direct mode tracks direct_bit without consuming the stream, that a missing bit drops busy and the line to idle, and that a reset during a burst returns the block to Manchester with on-off keying.

// File: rtl/rfenc_pkg.sv
package rfenc_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MD_MAN    = 2'b00,
    MD_BIP    = 2'b01,
    MD_NRZ    = 2'b10,
    MD_DIRECT = 2'b11
  } line_mode_e;
endpackage

// File: rtl/rfenc_cfg.sv
module rfenc_cfg
  import rfenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_fsk,
  output line_mode_e        mode_req,
  output logic              fsk_q,
  output logic              fsk_nxt
);
  // the modulation choice applies from the write edge onward
  assign fsk_nxt = cfg_we ? cfg_fsk : fsk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_req <= MD_MAN;
      fsk_q    <= 1'b0;
    end else begin
      if (cfg_we) mode_req <= line_mode_e'(cfg_mode);
      fsk_q <= fsk_nxt;
    end
  end
endmodule

// File: rtl/rfenc_seq.sv
module rfenc_seq
  import rfenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       half_tick,
  input  logic       in_valid,
  input  logic       in_data,
  output logic       in_ready,
  input  logic       direct_bit,
  input  line_mode_e mode_req,
  output line_mode_e mode_act,
  output logic       busy_q,
  output logic       lvl_nxt,
  output logic       active_nxt
);
  logic       phase_q, bit_q, lvl_q;
  logic       phase_n, bit_n, busy_n;
  line_mode_e mode_n;
  logic       at_edge;

  // a boundary closes the current bit: idle, single-slot modes, or second half
  always_comb begin
    at_edge = 1'b0;
    if (half_tick)
      at_edge = !busy_q || (mode_act == MD_NRZ) || (mode_act == MD_DIRECT) || phase_q;
  end

  assign in_ready = !rst && at_edge && (mode_req != MD_DIRECT);

  always_comb begin
    mode_n  = mode_act;
    busy_n  = busy_q;
    phase_n = phase_q;
    bit_n   = bit_q;
    lvl_nxt = lvl_q;
    if (at_edge) begin
      mode_n  = mode_req;
      phase_n = 1'b0;
      if (mode_req == MD_DIRECT) begin
        busy_n  = 1'b0;
        lvl_nxt = direct_bit;
      end else if (in_valid) begin
        busy_n = 1'b1;
        bit_n  = in_data;
        if (mode_req == MD_BIP) lvl_nxt = !lvl_q;
        else                    lvl_nxt = in_data;
      end else begin
        busy_n  = 1'b0;
        lvl_nxt = 1'b0;
      end
    end else if (half_tick) begin
      // second half of a two-slot symbol
      phase_n = 1'b1;
      if (mode_act == MD_MAN) lvl_nxt = !bit_q;
      else if (bit_q)         lvl_nxt = !lvl_q;
    end else if (mode_act == MD_DIRECT) begin
      lvl_nxt = direct_bit;
    end
  end

  assign active_nxt = busy_n || (mode_n == MD_DIRECT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_act <= MD_MAN;
      busy_q   <= 1'b0;
      phase_q  <= 1'b0;
      bit_q    <= 1'b0;
      lvl_q    <= 1'b0;
    end else begin
      mode_act <= mode_n;
      busy_q   <= busy_n;
      phase_q  <= phase_n;
      bit_q    <= bit_n;
      lvl_q    <= lvl_nxt;
    end
  end
endmodule

// File: rtl/rfenc_out.sv
module rfenc_out (
  input  logic clk,
  input  logic rst,
  input  logic fsk_nxt,
  input  logic lvl_nxt,
  input  logic active_nxt,
  output logic key_out,
  output logic data_one
);
  always_ff @(posedge clk) begin
    if (rst) begin
      key_out  <= 1'b0;
      data_one <= 1'b0;
    end else begin
      key_out  <= fsk_nxt ? active_nxt : lvl_nxt;
      data_one <= lvl_nxt;
    end
  end
endmodule

// File: rtl/rf_line_encoder.sv
module rf_line_encoder
  import rfenc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              half_tick,
  input  logic              in_valid,
  input  logic              in_data,
  output logic              in_ready,
  input  logic              direct_bit,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_fsk,
  output logic              key_out,
  output logic              data_one,
  output logic              busy
);
  line_mode_e mode_req, mode_act;
  logic       fsk_q, fsk_nxt, lvl_nxt, active_nxt;

  rfenc_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_fsk(cfg_fsk),
    .mode_req(mode_req), .fsk_q(fsk_q), .fsk_nxt(fsk_nxt)
  );

  rfenc_seq u_seq (
    .clk(clk), .rst(rst), .half_tick(half_tick), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .direct_bit(direct_bit), .mode_req(mode_req), .mode_act(mode_act),
    .busy_q(busy), .lvl_nxt(lvl_nxt), .active_nxt(active_nxt)
  );

  rfenc_out u_out (
    .clk(clk), .rst(rst), .fsk_nxt(fsk_nxt), .lvl_nxt(lvl_nxt), .active_nxt(active_nxt),
    .key_out(key_out), .data_one(data_one)
  );
endmodule

// File: rtl/rf_line_encoder_chk.sv
module rf_line_encoder_chk
  import rfenc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       half_tick,
  input logic       in_valid,
  input logic       in_ready,
  input logic       direct_bit,
  input logic       cfg_we,
  input logic       key_out,
  input logic       data_one,
  input logic       busy,
  input logic       fsk_q,
  input line_mode_e mode_req,
  input line_mode_e mode_act
);
  // R5
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> half_tick);

  // R4
  direct_no_take_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (mode_req != MD_DIRECT));

  // R4
  direct_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_act == MD_DIRECT && !half_tick) |=> (data_one == $past(direct_bit)));

  // R6
  idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> (!busy && !data_one && !key_out));

  // R7
  ook_key_chk: assert property (@(posedge clk) disable iff (rst)
    !fsk_q |-> (key_out == data_one));

  // R8
  fsk_carrier_chk: assert property (@(posedge clk) disable iff (rst)
    (fsk_q && busy) |-> key_out);

  // R11
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    (!half_tick && mode_act != MD_DIRECT && !cfg_we) |=> ($stable(key_out) && $stable(data_one)));

  // R10
  always_comb begin
    if (rst) reset_ready_chk: assert (!in_ready);
  end
endmodule

bind rf_line_encoder rf_line_encoder_chk u_chk (
  .clk(clk), .rst(rst), .half_tick(half_tick), .in_valid(in_valid), .in_ready(in_ready),
  .direct_bit(direct_bit), .cfg_we(cfg_we), .key_out(key_out), .data_one(data_one),
  .busy(busy), .fsk_q(fsk_q), .mode_req(mode_req), .mode_act(mode_act)
);

// File: tb/sim_rf_line_encoder.sv
`timescale 1ns/1ps
module sim_rf_line_encoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic half_tick = 1'b0, in_valid = 1'b0, in_data = 1'b0, direct_bit = 1'b0;
  logic cfg_we = 1'b0, cfg_fsk = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic in_ready, key_out, data_one, busy;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  rf_line_encoder u0 (
    .clk(clk), .rst(rst), .half_tick(half_tick), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .direct_bit(direct_bit), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_fsk(cfg_fsk), .key_out(key_out), .data_one(data_one), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] md, input logic fs);
    @(negedge clk); cfg_we = 1'b1; cfg_mode = md; cfg_fsk = fs;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // one strobe cycle; returns whether the bit was taken at that edge
  task automatic tick(input logic v, input logic d, output logic took);
    @(negedge clk); half_tick = 1'b1; in_valid = v; in_data = d;
    #0.5 took = v && in_ready;
    @(negedge clk); half_tick = 1'b0; in_valid = 1'b0;
  endtask

  task automatic run_stream(input logic [1:0] md, input logic fs, input logic [7:0] pat,
                            input int n, input int sw_at, input logic [1:0] sw_md,
                            input bit setup, input string tag);
    logic e [0:31];
    int k, idx, accepted, total;
    logic r, tk;
    logic [1:0] cm;
    cm = md; r = 1'b0; k = 0;
    for (int i = 0; i < n; i++) begin
      if (sw_at >= 0 && k >= sw_at) cm = sw_md;
      if (cm == 2'b00) begin e[k] = pat[i]; e[k+1] = !pat[i]; k += 2; end
      else if (cm == 2'b01) begin r = !r; e[k] = r; if (pat[i]) r = !r; e[k+1] = r; k += 2; end
      else begin e[k] = pat[i]; k += 1; end
    end
    e[k] = 1'b0;
    total = k + 1;
    if (setup) begin
      cfg_write(md, fs);
      tick(1'b0, 1'b0, tk);
      chk(!busy && !key_out && !data_one, "R6 setup idle", {busy, key_out, data_one}, 0);
    end
    idx = 0; accepted = 0;
    for (int j = 0; j < total; j++) begin
      logic eb, kk, d1;
      tick(idx < n, pat[idx[2:0]], tk);
      if (tk) begin idx++; accepted++; end
      eb = (j < total - 1);
      chk(data_one == e[j], tag, data_one, e[j]);
      chk(busy == eb, (j == total - 1) ? "R6 busy" : "R5 busy", busy, eb);
      chk(key_out == (fs ? eb : e[j]), fs ? "R8 key" : "R7 key", key_out, fs ? eb : e[j]);
      kk = key_out; d1 = data_one;
      if (j + 1 == sw_at) cfg_write(sw_md, fs);
      else @(negedge clk);
      @(negedge clk);
      chk(key_out == kk && data_one == d1, "R11 hold", {key_out, data_one}, {kk, d1});
    end
    chk(accepted == n, "R5 count", accepted, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    logic tk;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!key_out && !data_one && !busy, "R10 reset state", {key_out, data_one, busy}, 0);

    // exhaustive 4-bit sweep: modes x modulation x pattern
    for (int m = 0; m < 3; m++)
      for (int f = 0; f < 2; f++)
        for (int p = 0; p < 16; p++)
          run_stream(m[1:0], f[0], p[7:0], 4, -1, 2'b00, 1'b1,
                     (m == 0) ? "R1 level" : (m == 1) ? "R2 level" : "R3 level");

    // longer bursts
    run_stream(2'b01, 1'b0, 8'b1011_0010, 8, -1, 2'b00, 1'b1, "R2 long");
    run_stream(2'b10, 1'b1, 8'b0110_1101, 8, -1, 2'b00, 1'b1, "R3 long");

    // mode changes part-way through a bit
    run_stream(2'b00, 1'b0, 8'b0000_1101, 4, 3, 2'b10, 1'b1, "R9 man->nrz");
    run_stream(2'b10, 1'b0, 8'b0000_0110, 5, 2, 2'b00, 1'b1, "R9 nrz->man");
    run_stream(2'b00, 1'b1, 8'b0000_1011, 4, 1, 2'b10, 1'b1, "R9 mid-first");

    // direct mode, both modulations
    for (int f = 0; f < 2; f++) begin
      cfg_write(2'b11, f[0]);
      tick(1'b0, 1'b0, tk);
      for (int s = 0; s < 6; s++) begin
        logic b;
        b = s[0] ^ s[2];
        @(negedge clk); direct_bit = b;
        @(negedge clk);
        chk(data_one == b, "R4 follow", data_one, b);
        chk(key_out == (f[0] ? 1'b1 : b), f[0] ? "R8 direct key" : "R7 direct key",
            key_out, f[0] ? 1'b1 : b);
      end
      tick(1'b1, 1'b1, tk);
      chk(tk == 1'b0, "R4 no take", tk, 0);
      chk(!busy, "R4 not busy", busy, 0);
      direct_bit = 1'b0;
      cfg_write(2'b00, 1'b0);
      tick(1'b0, 1'b0, tk);
      chk(!key_out && !data_one, "R6 leave direct", {key_out, data_one}, 0);
    end

    // reset restores Manchester with on-off keying
    cfg_write(2'b10, 1'b1);
    tick(1'b0, 1'b0, tk);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!key_out && !data_one && !busy, "R10 after reset", {key_out, data_one, busy}, 0);
    run_stream(2'b00, 1'b0, 8'b0000_0001, 2, -1, 2'b00, 1'b0, "R10 man default");

    // reset in the middle of a burst
    cfg_write(2'b01, 1'b1);
    tick(1'b0, 1'b0, tk);
    tick(1'b1, 1'b1, tk);
    chk(busy && key_out, "R8 burst on", {busy, key_out}, 3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(!key_out && !data_one && !busy, "R10 mid-burst", {key_out, data_one, busy}, 0);
    run_stream(2'b00, 1'b0, 8'b0000_0010, 2, -1, 2'b00, 1'b0, "R10 man after");

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule